// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block sits in an SDRAM controller beside the command path. When a read or write command is issued, it takes the starting column and produces one column address per clock for the length of the burst. The length and the wrap order come from a mode word. The controller loads that word when it writes the mode register, which it addresses with bank select zero. Loads aimed at any other bank are ignored.

Fixed bursts of 1, 2, 4 or 8 stay inside an aligned block of that size. The upper column bits pick the block, and the low bits wrap in sequential or interleaved order. A full-page burst counts upward through the whole row, wrapping at the row end, until a burst stop arrives. A new start may arrive on any clock and cuts off the burst in progress. The sequencer also stores the CAS latency from the mode word and exports it for the data-alignment logic. It rejects any mode word it cannot honour, raises an error flag, and keeps its previous mode.

Top module: `sdr_colseq`

## Requirements
- R1: A mode load is accepted only when `mode_bank_i` is 0. A load with any other bank value changes neither the burst mode, nor `cas_lat_o`, nor `cfg_err_o`.
- R2: Mode bits [2:0] set the burst length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives full page.
- R3: Mode bit 3 sets the wrap order: 0 is sequential and 1 is interleaved.
- R4: Mode bits [6:4] hold the CAS latency. The codes 010 (2) and 011 (3) are legal, and `cas_lat_o` shows the stored value from the cycle after the load.
- R5: A load is rejected in these cases: a length code of 100, 101 or 110; a latency code other than 2 or 3; full page with interleaved order; or any nonzero bit in [MODE_W-1:7]. On a rejected load, `cfg_err_o` is 1 from the next cycle and the previous mode stays in force. Any accepted load clears `cfg_err_o`.
- R6: When `start_i` is sampled high, in the next cycle `col_valid_o` is 1 and `col_o` equals `start_col_i`. After that, one address follows per cycle.
- R7: In sequential order with burst length N, the upper column bits stay fixed, and the low log2(N) bits run (start + k) mod N for k = 0..N-1. Example: length 8 from 5 gives 5,6,7,0,1,2,3,4.
- R8: In interleaved order, the low log2(N) bits are the start offset XOR k. Example: length 8 from 5 gives 5,4,7,6,1,0,3,2.
- R9: In full-page mode, the address is start + k modulo 2^COL_W. It runs until it is stopped, and `col_last_o` stays 0 throughout.
- R10: In a fixed burst, `col_last_o` is 1 exactly with the N-th address, and `col_valid_o` is 0 in the following cycle. A length-1 burst shows last with its only address.
- R11: When `stop_i` is sampled high without `start_i`, `col_valid_o` is 0 from the next cycle. When both are high, the start wins.
- R12: A start during a burst abandons the old burst. The next cycle shows the new start column, and the new burst runs its full length.
- R13: After reset, `col_valid_o`, `col_last_o` and `cfg_err_o` are 0, the mode is length 1 sequential, and `cas_lat_o` is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_load_i | input | 1 | Mode register write strobe |
| mode_bank_i | input | BANK_W | Bank select sent with the mode write |
| mode_value_i | input | MODE_W | Address-bus value of the mode write |
| start_i | input | 1 | Read/write command strobe |
| start_col_i | input | COL_W | Starting column of the command |
| stop_i | input | 1 | Burst stop |
| col_o | output | COL_W | Current column address |
| col_valid_o | output | 1 | `col_o` is a burst address |
| col_last_o | output | 1 | Final address of a fixed-length burst |
| cas_lat_o | output | 3 | Stored CAS latency |
| cfg_err_o | output | 1 | Last mode load was rejected |

## Verification
A corrupted offset or block base shows on `col_o` as soon as the second address of a burst, as a column outside the aligned block or one out of order. A miscounted burst shows at the burst end: `col_last_o` comes on the wrong beat, or `col_valid_o` does not drop the cycle after it. A wrongly accepted or wrongly rejected mode word shows in the cycle after the load, on `cfg_err_o` and `cas_lat_o`. It also shows in the length and order of the very next burst.

// File: rtl/sdr_colseq_pkg.sv
package sdr_colseq_pkg;

   localparam int OFF_W = 3;   // widest fixed burst is 8 beats

   typedef enum logic [2:0] {
      BLEN_1    = 3'b000,
      BLEN_2    = 3'b001,
      BLEN_4    = 3'b010,
      BLEN_8    = 3'b011,
      BLEN_PAGE = 3'b111
   } blen_e;

   typedef struct packed {
      blen_e      blen;
      logic       ilv;
      logic [2:0] cas;
   } mode_t;

   localparam mode_t MODE_RESET = '{blen: BLEN_1, ilv: 1'b0, cas: 3'd2};

   function automatic logic [OFF_W-1:0] blen_mask(blen_e b);
      case (b)
         BLEN_2:  return 3'b001;
         BLEN_4:  return 3'b011;
         BLEN_8:  return 3'b111;
         default: return 3'b000;
      endcase
   endfunction

   function automatic logic cas_legal(logic [2:0] c);
      return (c == 3'd2) || (c == 3'd3);
   endfunction

endpackage

// File: rtl/sdr_colseq_mode.sv
module sdr_colseq_mode
   import sdr_colseq_pkg::*;
#(
   parameter int MODE_W  = 13,
   parameter bit PAGE_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [MODE_W-1:0] value_i,
   output mode_t             mode_o,
   output logic              err_o
);

   localparam int OPM_W = MODE_W - 7;

   logic [2:0]       bl_code;
   logic             ilv_bit;
   logic [2:0]       cas_code;
   logic [OPM_W-1:0] opm_bits;
   logic             bl_ok;
   logic             word_ok;
   mode_t            mode_q;
   logic             err_q;

   assign bl_code  = value_i[2:0];
   assign ilv_bit  = value_i[3];
   assign cas_code = value_i[6:4];
   assign opm_bits = value_i[MODE_W-1:7];

   always_comb begin
      case (bl_code)
         3'b000, 3'b001, 3'b010, 3'b011: bl_ok = 1'b1;
         3'b111:                         bl_ok = PAGE_EN && !ilv_bit;
         default:                        bl_ok = 1'b0;
      endcase
   end

   assign word_ok = bl_ok && cas_legal(cas_code) && (opm_bits == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= MODE_RESET;
         err_q  <= 1'b0;
      end else if (load_i) begin
         if (word_ok) begin
            mode_q.blen <= blen_e'(bl_code);
            mode_q.ilv  <= ilv_bit;
            mode_q.cas  <= cas_code;
            err_q       <= 1'b0;
         end else begin
            err_q       <= 1'b1;
         end
      end
   end

   assign mode_o = mode_q;
   assign err_o  = err_q;

endmodule

// File: rtl/sdr_colseq_order.sv
module sdr_colseq_order
   import sdr_colseq_pkg::*;
#(
   parameter int COL_W   = 10,
   parameter bit PAGE_EN = 1'b1
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] cnt_i,
   input  logic [OFF_W-1:0] mask_i,
   input  logic             ilv_i,
   input  logic             page_i,
   output logic [COL_W-1:0] col_o
);

   logic [OFF_W-1:0] off;
   logic [OFF_W-1:0] seq_low;
   logic [OFF_W-1:0] ilv_low;
   logic [OFF_W-1:0] low;
   logic [COL_W-1:0] fix_col;

   assign off     = base_i[OFF_W-1:0] & mask_i;
   assign seq_low = (off + cnt_i[OFF_W-1:0]) & mask_i;
   assign ilv_low = (off ^ cnt_i[OFF_W-1:0]) & mask_i;
   assign low     = ilv_i ? ilv_low : seq_low;

   // Wrapped bits come from the burst counter, the rest from the block base.
   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      if (i < OFF_W) begin : g_low
         assign fix_col[i] = mask_i[i] ? low[i] : base_i[i];
      end else begin : g_high
         assign fix_col[i] = base_i[i];
      end
   end

   if (PAGE_EN) begin : g_page
      logic [COL_W-1:0] page_col;
      assign page_col = base_i + cnt_i;
      assign col_o    = page_i ? page_col : fix_col;
   end else begin : g_nopage
      assign col_o = fix_col;
   end

endmodule

// File: rtl/sdr_colseq_ctrl.sv
module sdr_colseq_ctrl
   import sdr_colseq_pkg::*;
#(
   parameter int COL_W   = 10,
   parameter bit PAGE_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic             stop_i,
   input  mode_t            mode_i,
   output logic [COL_W-1:0] base_o,
   output logic [COL_W-1:0] cnt_o,
   output logic [OFF_W-1:0] mask_o,
   output logic             ilv_o,
   output logic             page_o,
   output logic             active_o,
   output logic             last_o
);

   logic             active_q;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] cnt_q;
   logic [OFF_W-1:0] mask_q;
   logic             ilv_q;
   logic             page_q;
   logic             at_end;

   if (PAGE_EN) begin : g_page
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      page_q <= 1'b0;
         else if (start_i) page_q <= (mode_i.blen == BLEN_PAGE);
      end
   end else begin : g_nopage
      assign page_q = 1'b0;
   end

   assign at_end = !page_q && (cnt_q[OFF_W-1:0] == mask_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_q <= 1'b0;
         base_q   <= '0;
         cnt_q    <= '0;
         mask_q   <= '0;
         ilv_q    <= 1'b0;
      end else if (start_i) begin
         active_q <= 1'b1;
         base_q   <= start_col_i;
         cnt_q    <= '0;
         mask_q   <= blen_mask(mode_i.blen);
         ilv_q    <= mode_i.ilv;
      end else if (stop_i) begin
         active_q <= 1'b0;
      end else if (active_q) begin
         if (at_end) active_q <= 1'b0;
         else        cnt_q    <= cnt_q + 1'b1;
      end
   end

   assign base_o   = base_q;
   assign cnt_o    = cnt_q;
   assign mask_o   = mask_q;
   assign ilv_o    = ilv_q;
   assign page_o   = page_q;
   assign active_o = active_q;
   assign last_o   = active_q && at_end;

endmodule

// File: rtl/sdr_colseq.sv
module sdr_colseq
   import sdr_colseq_pkg::*;
#(
   parameter int COL_W   = 10,
   parameter int MODE_W  = 13,
   parameter int BANK_W  = 2,
   parameter bit PAGE_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mode_load_i,
   input  logic [BANK_W-1:0] mode_bank_i,
   input  logic [MODE_W-1:0] mode_value_i,
   input  logic              start_i,
   input  logic [COL_W-1:0]  start_col_i,
   input  logic              stop_i,
   output logic [COL_W-1:0]  col_o,
   output logic              col_valid_o,
   output logic              col_last_o,
   output logic [2:0]        cas_lat_o,
   output logic              cfg_err_o
);

   if (COL_W < OFF_W) begin : g_bad_col
      $error("sdr_colseq: COL_W must cover an 8-beat block");
   end
   if (MODE_W < 8) begin : g_bad_mode
      $error("sdr_colseq: MODE_W must hold the fields up to bit 6 plus an operating field");
   end
   if (BANK_W < 1) begin : g_bad_bank
      $error("sdr_colseq: BANK_W must be at least 1");
   end

   mode_t            mode;
   logic             mode_wr;
   logic [COL_W-1:0] base;
   logic [COL_W-1:0] cnt;
   logic [OFF_W-1:0] mask;
   logic             ilv;
   logic             page;

   assign mode_wr = mode_load_i && (mode_bank_i == '0);

   sdr_colseq_mode #(.MODE_W(MODE_W), .PAGE_EN(PAGE_EN)) u_mode (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (mode_wr),
      .value_i (mode_value_i),
      .mode_o  (mode),
      .err_o   (cfg_err_o)
   );

   sdr_colseq_ctrl #(.COL_W(COL_W), .PAGE_EN(PAGE_EN)) u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i),
      .start_col_i (start_col_i),
      .stop_i      (stop_i),
      .mode_i      (mode),
      .base_o      (base),
      .cnt_o       (cnt),
      .mask_o      (mask),
      .ilv_o       (ilv),
      .page_o      (page),
      .active_o    (col_valid_o),
      .last_o      (col_last_o)
   );

   sdr_colseq_order #(.COL_W(COL_W), .PAGE_EN(PAGE_EN)) u_order (
      .base_i (base),
      .cnt_i  (cnt),
      .mask_i (mask),
      .ilv_i  (ilv),
      .page_i (page),
      .col_o  (col_o)
   );

   assign cas_lat_o = mode.cas;

endmodule

// File: rtl/sdr_colseq_chk.sv
module sdr_colseq_chk #(
   parameter int COL_W  = 10,
   parameter int MODE_W = 13,
   parameter int BANK_W = 2
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              mode_load_i,
   input logic [BANK_W-1:0] mode_bank_i,
   input logic [MODE_W-1:0] mode_value_i,
   input logic              start_i,
   input logic [COL_W-1:0]  start_col_i,
   input logic              stop_i,
   input logic [COL_W-1:0]  col_o,
   input logic              col_valid_o,
   input logic              col_last_o,
   input logic [2:0]        cas_lat_o,
   input logic              cfg_err_o
);

   assert_other_bank_ignored_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_load_i && mode_bank_i != '0) |=> ($stable(cas_lat_o) && $stable(cfg_err_o)));

   assert_cas_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cas_lat_o == 3'd2) || (cas_lat_o == 3'd3));

   assert_load_outcome_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_load_i && mode_bank_i == '0) |=>
         (cfg_err_o ? $stable(cas_lat_o) : (cas_lat_o == $past(mode_value_i[6:4]))));

   assert_start_col_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (col_valid_o && col_o == $past(start_col_i)));

   assert_last_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      col_last_o |-> col_valid_o);

   assert_end_after_last_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (col_last_o && !start_i) |=> !col_valid_o);

   assert_stop_ends_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_i && !start_i) |=> !col_valid_o);

   assert_burst_continues_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (col_valid_o && !col_last_o && !stop_i) |=> col_valid_o);

endmodule

bind sdr_colseq sdr_colseq_chk #(.COL_W(COL_W), .MODE_W(MODE_W), .BANK_W(BANK_W)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .mode_load_i  (mode_load_i),
   .mode_bank_i  (mode_bank_i),
   .mode_value_i (mode_value_i),
   .start_i      (start_i),
   .start_col_i  (start_col_i),
   .stop_i       (stop_i),
   .col_o        (col_o),
   .col_valid_o  (col_valid_o),
   .col_last_o   (col_last_o),
   .cas_lat_o    (cas_lat_o),
   .cfg_err_o    (cfg_err_o)
);

// File: tb/sdr_colseq_bench.sv
module sdr_colseq_bench;

   localparam int COL_W  = 10;
   localparam int MODE_W = 13;
   localparam int BANK_W = 2;

   logic              clk = 1'b0;
   logic              rst_ni = 1'b0;
   logic              mode_load_i = 1'b0;
   logic [BANK_W-1:0] mode_bank_i = '0;
   logic [MODE_W-1:0] mode_value_i = '0;
   logic              start_i = 1'b0;
   logic [COL_W-1:0]  start_col_i = '0;
   logic              stop_i = 1'b0;
   logic [COL_W-1:0]  col_o;
   logic              col_valid_o;
   logic              col_last_o;
   logic [2:0]        cas_lat_o;
   logic              cfg_err_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   sdr_colseq #(.COL_W(COL_W), .MODE_W(MODE_W), .BANK_W(BANK_W)) u_sdr_colseq (
      .clk_i        (clk),
      .rst_ni       (rst_ni),
      .mode_load_i  (mode_load_i),
      .mode_bank_i  (mode_bank_i),
      .mode_value_i (mode_value_i),
      .start_i      (start_i),
      .start_col_i  (start_col_i),
      .stop_i       (stop_i),
      .col_o        (col_o),
      .col_valid_o  (col_valid_o),
      .col_last_o   (col_last_o),
      .cas_lat_o    (cas_lat_o),
      .cfg_err_o    (cfg_err_o)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", what, act, exp, $time);
      end
   endtask

   // Mode word: bits [2:0] length code, bit 3 order, bits [6:4] latency.
   function automatic logic [MODE_W-1:0] mw(input logic [2:0] bl, input logic t, input logic [2:0] cl);
      return {{(MODE_W-7){1'b0}}, cl, t, bl};
   endfunction

   function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s, input int n,
                                                 input bit ilv, input bit page, input int k);
      int off, idx;
      if (page) return COL_W'((int'(s) + k) % (1 << COL_W));
      off = int'(s) % n;
      idx = ilv ? (off ^ k) : ((off + k) % n);
      return COL_W'(int'(s) - off + idx);
   endfunction

   // All tasks are entered and left just after a falling edge.
   task automatic load_mode(input logic [BANK_W-1:0] bank, input logic [MODE_W-1:0] v);
      mode_load_i  = 1'b1;
      mode_bank_i  = bank;
      mode_value_i = v;
      @(negedge clk);
      mode_load_i  = 1'b0;
      mode_bank_i  = '0;
   endtask

   // Start a burst and check "cycles" beats of it.
   task automatic burst(input logic [COL_W-1:0] sc, input int n, input bit ilv, input bit page,
                        input int cycles, input bit with_stop, input string tag);
      start_i     = 1'b1;
      start_col_i = sc;
      stop_i      = with_stop;
      @(negedge clk);
      start_i = 1'b0;
      stop_i  = 1'b0;
      for (int k = 0; k < cycles; k++) begin
         chk({tag, " valid"}, 32'(col_valid_o), 32'd1);
         chk({tag, " col"}, 32'(col_o), 32'(exp_col(sc, n, ilv, page, k)));
         chk({tag, " R10 last"}, 32'(col_last_o), 32'(!page && k == n - 1));
         if (k < cycles - 1) @(negedge clk);
      end
   endtask

   task automatic expect_idle(input string tag);
      @(negedge clk);
      chk({tag, " idle valid"}, 32'(col_valid_o), 32'd0);
      chk({tag, " idle last"}, 32'(col_last_o), 32'd0);
   endtask

   task automatic stop_now(input string tag);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      chk({tag, " R11 stopped"}, 32'(col_valid_o), 32'd0);
   endtask

   task automatic t_reset;
      chk("R13 reset valid", 32'(col_valid_o), 32'd0);
      chk("R13 reset last", 32'(col_last_o), 32'd0);
      chk("R13 reset cas", 32'(cas_lat_o), 32'd2);
      chk("R13 reset err", 32'(cfg_err_o), 32'd0);
      burst(10'h123, 1, 1'b0, 1'b0, 1, 1'b0, "R13 default length 1");
      expect_idle("R13");
   endtask

   task automatic t_fixed_orders;
      load_mode('0, mw(3'b001, 1'b0, 3'd2));
      chk("R2 err after BL2", 32'(cfg_err_o), 32'd0);
      burst(10'h003, 2, 1'b0, 1'b0, 2, 1'b0, "R2 R7 BL2 seq");
      expect_idle("R2");
      load_mode('0, mw(3'b010, 1'b1, 3'd3));
      chk("R4 cas 3", 32'(cas_lat_o), 32'd3);
      burst(10'h016, 4, 1'b1, 1'b0, 4, 1'b0, "R3 R8 BL4 ilv");
      expect_idle("R8");
      load_mode('0, mw(3'b011, 1'b0, 3'd3));
      burst(10'h045, 8, 1'b0, 1'b0, 8, 1'b0, "R7 BL8 seq");
      expect_idle("R7");
      load_mode('0, mw(3'b011, 1'b1, 3'd2));
      chk("R4 cas 2", 32'(cas_lat_o), 32'd2);
      burst(10'h045, 8, 1'b1, 1'b0, 8, 1'b0, "R8 BL8 ilv");
      expect_idle("R8");
   endtask

   task automatic t_literal_orders;
      logic [COL_W-1:0] seq_exp [8] = '{10'h3CD, 10'h3CE, 10'h3CF, 10'h3C8,
                                        10'h3C9, 10'h3CA, 10'h3CB, 10'h3CC};
      logic [COL_W-1:0] ilv_exp [8] = '{10'h3CD, 10'h3CC, 10'h3CF, 10'h3CE,
                                        10'h3C9, 10'h3C8, 10'h3CB, 10'h3CA};
      load_mode('0, mw(3'b011, 1'b0, 3'd3));
      start_i = 1'b1; start_col_i = 10'h3CD;
      @(negedge clk); start_i = 1'b0;
      for (int k = 0; k < 8; k++) begin
         chk("R7 literal 5,6,7,0,1,2,3,4", 32'(col_o), 32'(seq_exp[k]));
         @(negedge clk);
      end
      load_mode('0, mw(3'b011, 1'b1, 3'd3));
      start_i = 1'b1; start_col_i = 10'h3CD;
      @(negedge clk); start_i = 1'b0;
      for (int k = 0; k < 8; k++) begin
         chk("R8 literal 5,4,7,6,1,0,3,2", 32'(col_o), 32'(ilv_exp[k]));
         @(negedge clk);
      end
      chk("R10 literal end", 32'(col_valid_o), 32'd0);
   endtask

   task automatic t_full_page;
      load_mode('0, mw(3'b111, 1'b0, 3'd3));
      chk("R9 page accepted", 32'(cfg_err_o), 32'd0);
      burst(10'h3FD, 0, 1'b0, 1'b1, 20, 1'b0, "R9 page wrap");
      stop_now("R9");
      expect_idle("R9");
   endtask

   task automatic t_config_errors;
      load_mode('0, mw(3'b011, 1'b0, 3'd3));
      load_mode('0, mw(3'b100, 1'b0, 3'd2));
      chk("R5 reserved length err", 32'(cfg_err_o), 32'd1);
      chk("R5 reserved length keeps cas", 32'(cas_lat_o), 32'd3);
      burst(10'h045, 8, 1'b0, 1'b0, 8, 1'b0, "R5 kept BL8");
      expect_idle("R5");
      load_mode('0, mw(3'b001, 1'b0, 3'b001));
      chk("R5 reserved latency err", 32'(cfg_err_o), 32'd1);
      chk("R5 reserved latency keeps cas", 32'(cas_lat_o), 32'd3);
      load_mode('0, mw(3'b111, 1'b1, 3'd2));
      chk("R5 page+ilv err", 32'(cfg_err_o), 32'd1);
      load_mode('0, mw(3'b011, 1'b0, 3'd2) | (MODE_W'(1) << 9));
      chk("R5 upper bits err", 32'(cfg_err_o), 32'd1);
      chk("R5 upper bits keep cas", 32'(cas_lat_o), 32'd3);
      burst(10'h2A1, 8, 1'b0, 1'b0, 8, 1'b0, "R5 still BL8 seq");
      expect_idle("R5");
      load_mode('0, mw(3'b010, 1'b0, 3'd2));
      chk("R5 good load clears err", 32'(cfg_err_o), 32'd0);
      chk("R5 good load cas", 32'(cas_lat_o), 32'd2);
   endtask

   task automatic t_bank_ignore;
      load_mode('0, mw(3'b011, 1'b0, 3'd3));
      load_mode(2'b01, mw(3'b000, 1'b1, 3'd2));
      chk("R1 bank1 cas", 32'(cas_lat_o), 32'd3);
      chk("R1 bank1 err", 32'(cfg_err_o), 32'd0);
      load_mode(2'b10, mw(3'b100, 1'b0, 3'd2));
      chk("R1 bank2 bad word no err", 32'(cfg_err_o), 32'd0);
      burst(10'h0F3, 8, 1'b0, 1'b0, 8, 1'b0, "R1 mode kept BL8 seq");
      expect_idle("R1");
   endtask

   task automatic t_stop_restart;
      load_mode('0, mw(3'b011, 1'b0, 3'd3));
      burst(10'h010, 8, 1'b0, 1'b0, 3, 1'b0, "R11 pre-stop");
      stop_now("R11 fixed");
      expect_idle("R11");
      burst(10'h010, 8, 1'b0, 1'b0, 3, 1'b0, "R12 first");
      burst(10'h02B, 8, 1'b0, 1'b0, 8, 1'b1, "R12 R11 restart with stop");
      expect_idle("R12");
      load_mode('0, mw(3'b001, 1'b1, 3'd3));
      burst(10'h200, 2, 1'b1, 1'b0, 1, 1'b0, "R12 back-to-back a");
      burst(10'h201, 2, 1'b1, 1'b0, 2, 1'b0, "R12 back-to-back b");
      expect_idle("R12");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      @(negedge clk);
      t_reset();
      t_fixed_orders();
      t_literal_orders();
      t_full_page();
      t_config_errors();
      t_bank_ignore();
      t_stop_restart();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      #4_000_000;
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule